// File: doc/BRIEF.md
# Bus Access Match Comparator

This block watches a processor memory bus and raises a single-cycle match pulse whenever a valid access meets a programmed set of conditions. The conditions are an exact compare address, an optional read/write direction, an optional access size (byte or word) and an optional data compare. The data compare is split into byte lanes, and each lane has its own expected value and its own bit mask. A debug or monitoring unit uses the pulse to count, trace or break on particular memory accesses.

The address compare is exact. An access matches only when its start address equals the programmed address. A word access that begins one byte lower also covers the programmed byte, but it never matches. Data on the bus is big-endian. The byte at the access address sits in the upper lane (bits [15:8]), and for a word access the byte at the next address sits in bits [7:0]. A small register port writes the control bits, the compare address, the expected data and the masks. Writes take effect from the next clock.

Top module: `bus_match_cmp`

## Requirements
- R1: While `rst_i` is high, `hit_o` is 0 on the following clock, and every configuration register is cleared to 0, which leaves the comparator disabled.
- R2: Writes use `cfg_we_i` with `cfg_sel_i`: 0 = control, 1 = compare address, 2 = expected data, 3 = data masks. Control bit 0 is enable, bit 1 is direction-qualify enable, bit 2 is the direction value (1 = read), bit 3 is size-qualify enable and bit 4 is the size value (1 = byte, 0 = word). While enable is 0, no access produces a match.
- R3: An access matches only when `bus_addr_i` equals the compare address exactly. A word access at the compare address minus one does not match.
- R4: With size qualification off, both byte accesses (`bus_byte_i`=1) and word accesses (`bus_byte_i`=0) at the compare address match.
- R5: With size qualification on and the size value 0, only word accesses match.
- R6: With size qualification on and the size value 1, only byte accesses match.
- R7: With direction qualification on, a match also requires `bus_rnw_i` (1 = read) to equal the direction value. With it off, both directions match.
- R8: The expected-data register holds the upper-lane byte in bits [15:8] and the lower-lane byte in bits [7:0]. The mask register is laid out the same way. Only bits whose mask bit is 1 take part in the compare, and an all-zero mask disables the data compare.
- R9: With both lane masks at 0xFF and size qualification set to word, a match requires both bytes of the word to equal the expected data.
- R10: With size qualification set to byte and a non-zero lower-lane mask, a byte access still compares whatever bits [7:0] carry, so it can match on unintended data. This behaviour is kept.
- R11: `hit_o` is registered. It rises on the clock after a qualifying access with `bus_valid_i`=1 and stays high for one cycle only, unless the next cycle also carries a qualifying access.
- R12: An access with `bus_valid_i`=0 never produces a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Configuration register select |
| cfg_wdata_i | input | 16 | Configuration write data |
| bus_valid_i | input | 1 | Bus access valid strobe |
| bus_addr_i | input | 16 | Access start address |
| bus_rnw_i | input | 1 | 1 = read, 0 = write |
| bus_byte_i | input | 1 | 1 = byte access, 0 = word access |
| bus_data_i | input | 16 | Bus data, big-endian lanes |
| hit_o | output | 1 | Registered one-cycle match pulse |

## Verification
The bench builds the comparator with its default parameters: 16-bit addresses and a 16-bit data bus made of two byte lanes. This puts the ADDR-minus-one word overlap, the split of masks between the upper and lower lanes, and the unintended byte match through the lower lane all within reach of directed accesses. A behavioural model in the bench keeps shadow copies of the registers and predicts `hit_o` on every clock. Directed accesses then pin down each qualifier combination, partial masks and back-to-back pulses.

// File: rtl/bmc_pkg.sv
package bmc_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_DATA = 2'd2,
    SEL_MASK = 2'd3
  } cfg_sel_e;

  // control bits, enable in bit 0
  typedef struct packed {
    logic size_byte;
    logic size_en;
    logic dir_read;
    logic dir_en;
    logic enable;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
  localparam int LANE_W = 8;

endpackage

// File: rtl/bmc_cfg_regs.sv
module bmc_cfg_regs
  import bmc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              we_i,
  input  logic [1:0]        sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output ctrl_t             ctrl_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] exp_o,
  output logic [DATA_W-1:0] mask_o
);

  logic unused_wdata_hi;
  assign unused_wdata_hi = ^wdata_i[DATA_W-1:CTRL_W];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ctrl_o <= '0;
      addr_o <= '0;
      exp_o  <= '0;
      mask_o <= '0;
    end else if (we_i) begin
      unique case (cfg_sel_e'(sel_i))
        SEL_CTRL: ctrl_o <= ctrl_t'(wdata_i[CTRL_W-1:0]);
        SEL_ADDR: addr_o <= wdata_i[ADDR_W-1:0];
        SEL_DATA: exp_o  <= wdata_i;
        SEL_MASK: mask_o <= wdata_i;
        default:  ;
      endcase
    end
  end

endmodule

// File: rtl/bmc_qual.sv
module bmc_qual
  import bmc_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  ctrl_t             ctrl_i,
  input  logic [ADDR_W-1:0] cmp_addr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_rnw_i,
  input  logic              bus_byte_i,
  output logic              ok_o
);

  logic addr_ok, dir_ok, size_ok;

  always_comb begin
    addr_ok = (bus_addr_i == cmp_addr_i);
    dir_ok  = !ctrl_i.dir_en  || (bus_rnw_i  == ctrl_i.dir_read);
    size_ok = !ctrl_i.size_en || (bus_byte_i == ctrl_i.size_byte);
    ok_o    = ctrl_i.enable && addr_ok && dir_ok && size_ok;
  end

endmodule

// File: rtl/bmc_lane_cmp.sv
module bmc_lane_cmp #(
  parameter int W = 8
) (
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] exp_i,
  input  logic [W-1:0] mask_i,
  output logic         ok_o
);

  assign ok_o = ~|((data_i ^ exp_i) & mask_i);

endmodule

// File: rtl/bus_match_cmp.sv
module bus_match_cmp
  import bmc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  input  logic              bus_valid_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_rnw_i,
  input  logic              bus_byte_i,
  input  logic [DATA_W-1:0] bus_data_i,
  output logic              hit_o
);

  localparam int LANES = DATA_W / LANE_W;

  ctrl_t             cfg_ctrl;
  logic [ADDR_W-1:0] cfg_addr;
  logic [DATA_W-1:0] cfg_exp;
  logic [DATA_W-1:0] cfg_mask;
  logic              qual_ok;
  logic [LANES-1:0]  lane_ok;
  logic              hit_q;

  bmc_cfg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .we_i    (cfg_we_i),
    .sel_i   (cfg_sel_i),
    .wdata_i (cfg_wdata_i),
    .ctrl_o  (cfg_ctrl),
    .addr_o  (cfg_addr),
    .exp_o   (cfg_exp),
    .mask_o  (cfg_mask)
  );

  bmc_qual #(.ADDR_W(ADDR_W)) u_qual (
    .ctrl_i     (cfg_ctrl),
    .cmp_addr_i (cfg_addr),
    .bus_addr_i (bus_addr_i),
    .bus_rnw_i  (bus_rnw_i),
    .bus_byte_i (bus_byte_i),
    .ok_o       (qual_ok)
  );

  // lane 0 is the most significant byte, i.e. the lowest address
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int HI = DATA_W - 1 - g * LANE_W;
    bmc_lane_cmp #(.W(LANE_W)) u_cmp (
      .data_i (bus_data_i[HI -: LANE_W]),
      .exp_i  (cfg_exp[HI -: LANE_W]),
      .mask_i (cfg_mask[HI -: LANE_W]),
      .ok_o   (lane_ok[g])
    );
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) hit_q <= 1'b0;
    else       hit_q <= bus_valid_i && qual_ok && (&lane_ok);
  end

  assign hit_o = hit_q;

endmodule

// File: rtl/bus_match_cmp_chk.sv
module bus_match_cmp_chk
  import bmc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic              bus_valid_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              bus_rnw_i,
  input logic              bus_byte_i,
  input logic [DATA_W-1:0] bus_data_i,
  input logic              hit_o,
  input ctrl_t             cfg_ctrl,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [DATA_W-1:0] cfg_exp,
  input logic [DATA_W-1:0] cfg_mask
);

  // R1
  reset_clear_chk: assert property (@(posedge clk_i) rst_i |=> !hit_o);

  // R2
  enable_gate_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    hit_o |-> $past(cfg_ctrl.enable));

  // R12
  valid_only_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    hit_o |-> $past(bus_valid_i));

  // R3
  addr_exact_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    hit_o |-> $past(bus_addr_i) == $past(cfg_addr));

  // R7
  dir_qual_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (hit_o && $past(cfg_ctrl.dir_en)) |-> $past(bus_rnw_i) == $past(cfg_ctrl.dir_read));

  // R5
  size_qual_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (hit_o && $past(cfg_ctrl.size_en)) |-> $past(bus_byte_i) == $past(cfg_ctrl.size_byte));

  // R8
  data_mask_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    hit_o |-> (($past(bus_data_i) ^ $past(cfg_exp)) & $past(cfg_mask)) == '0);

endmodule

bind bus_match_cmp bus_match_cmp_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_i       (rst_i),
  .bus_valid_i (bus_valid_i),
  .bus_addr_i  (bus_addr_i),
  .bus_rnw_i   (bus_rnw_i),
  .bus_byte_i  (bus_byte_i),
  .bus_data_i  (bus_data_i),
  .hit_o       (hit_o),
  .cfg_ctrl    (cfg_ctrl),
  .cfg_addr    (cfg_addr),
  .cfg_exp     (cfg_exp),
  .cfg_mask    (cfg_mask)
);

// File: tb/bus_match_cmp_test.sv
`timescale 1ns/1ps
module bus_match_cmp_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic        bus_valid = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_rnw = 1'b0;
  logic        bus_byte = 1'b0;
  logic [15:0] bus_data = '0;
  logic        hit;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  bus_match_cmp uut (
    .clk_i(clk), .rst_i(rst), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .bus_valid_i(bus_valid), .bus_addr_i(bus_addr),
    .bus_rnw_i(bus_rnw), .bus_byte_i(bus_byte), .bus_data_i(bus_data),
    .hit_o(hit)
  );

  // behavioural reference model
  int m_ctrl = 0, m_addr = 0, m_exp = 0, m_mask = 0;
  bit m_hit = 0;

  function automatic bit predict();
    int hi_diff, lo_diff;
    if (!m_ctrl[0] || !bus_valid) return 0;
    if (int'(bus_addr) != m_addr) return 0;
    if (m_ctrl[1] && (bus_rnw != m_ctrl[2])) return 0;
    if (m_ctrl[3] && (bus_byte != m_ctrl[4])) return 0;
    hi_diff = ((int'(bus_data) / 256) ^ (m_exp / 256)) & (m_mask / 256);
    lo_diff = ((int'(bus_data) % 256) ^ (m_exp % 256)) & (m_mask % 256);
    return (hi_diff == 0) && (lo_diff == 0);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_hit = 0; m_ctrl = 0; m_addr = 0; m_exp = 0; m_mask = 0;
    end else begin
      m_hit = predict();
      if (cfg_we) begin
        case (cfg_sel)
          2'd0: m_ctrl = int'(cfg_wdata) % 32;
          2'd1: m_addr = int'(cfg_wdata);
          2'd2: m_exp  = int'(cfg_wdata);
          default: m_mask = int'(cfg_wdata);
        endcase
      end
    end
  end

  task automatic check(bit act, bit exp_v, string req);
    tests++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s: hit_o=%0b expected %0b at cycle %0d", req, act, exp_v, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (cycles > 1) check(hit, m_hit, {cur_req, " model"});
  end

  always @(posedge clk) begin
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic acc(input logic [15:0] a, input bit rnw, input bit byt,
                     input logic [15:0] d, input bit exp_v, input string req);
    cur_req = req;
    bus_valid = 1'b1; bus_addr = a; bus_rnw = rnw; bus_byte = byt; bus_data = d;
    @(negedge clk);
    check(hit, exp_v, req);
    bus_valid = 1'b0;
  endtask

  task automatic idle(input bit exp_v, input string req);
    cur_req = req;
    @(negedge clk);
    check(hit, exp_v, req);
  endtask

  localparam logic [15:0] A = 16'h4A20;

  initial begin
    repeat (3) @(negedge clk);
    check(hit, 1'b0, "R1");
    rst = 1'b0;
    // R1: cleared registers leave the block disabled
    acc(16'h0000, 1'b0, 1'b0, 16'h0000, 1'b0, "R1");

    wr(2'd1, A);
    // R2: not enabled yet
    acc(A, 1'b1, 1'b0, 16'h0, 1'b0, "R2");
    wr(2'd0, 16'h0001);
    acc(A, 1'b1, 1'b0, 16'h0, 1'b1, "R2");
    idle(1'b0, "R11");
    // R12: valid low
    cur_req = "R12";
    bus_addr = A; bus_valid = 1'b0;
    idle(1'b0, "R12");
    // R3: exact address only
    acc(A - 16'd1, 1'b1, 1'b0, 16'h0, 1'b0, "R3");
    acc(A + 16'd1, 1'b1, 1'b1, 16'h0, 1'b0, "R3");
    // R4: size not qualified
    acc(A, 1'b0, 1'b1, 16'h0, 1'b1, "R4");
    acc(A, 1'b0, 1'b0, 16'h0, 1'b1, "R4");
    // R11: back-to-back then single pulse
    idle(1'b0, "R11");
    // R5: word only
    wr(2'd0, 16'h0009);
    acc(A, 1'b1, 1'b0, 16'h0, 1'b1, "R5");
    acc(A, 1'b1, 1'b1, 16'h0, 1'b0, "R5");
    // R6: byte only
    wr(2'd0, 16'h0019);
    acc(A, 1'b1, 1'b1, 16'h0, 1'b1, "R6");
    acc(A, 1'b1, 1'b0, 16'h0, 1'b0, "R6");
    // R7: direction read only
    wr(2'd0, 16'h0007);
    acc(A, 1'b1, 1'b0, 16'h0, 1'b1, "R7");
    acc(A, 1'b0, 1'b0, 16'h0, 1'b0, "R7");
    wr(2'd0, 16'h0003);
    acc(A, 1'b0, 1'b1, 16'h0, 1'b1, "R7");
    acc(A, 1'b1, 1'b1, 16'h0, 1'b0, "R7");
    // R8: upper lane mask only
    wr(2'd0, 16'h0001);
    wr(2'd2, 16'h5A3C);
    wr(2'd3, 16'hFF00);
    acc(A, 1'b0, 1'b0, 16'h5A99, 1'b1, "R8");
    acc(A, 1'b0, 1'b0, 16'h5B3C, 1'b0, "R8");
    // R8: partial mask bits
    wr(2'd3, 16'hF000);
    acc(A, 1'b0, 1'b1, 16'h5F00, 1'b1, "R8");
    acc(A, 1'b0, 1'b1, 16'h4A00, 1'b0, "R8");
    // R8: lower lane mask only
    wr(2'd3, 16'h00FF);
    acc(A, 1'b0, 1'b0, 16'h003C, 1'b1, "R8");
    acc(A, 1'b0, 1'b0, 16'h5A3D, 1'b0, "R8");
    // R9: full word compare, word size
    wr(2'd0, 16'h0009);
    wr(2'd2, 16'h1234);
    wr(2'd3, 16'hFFFF);
    acc(A, 1'b1, 1'b0, 16'h1234, 1'b1, "R9");
    acc(A, 1'b1, 1'b0, 16'h1235, 1'b0, "R9");
    acc(A, 1'b1, 1'b0, 16'h1334, 1'b0, "R9");
    acc(A, 1'b1, 1'b1, 16'h1234, 1'b0, "R9");
    // R10: byte size with lower-lane mask, unintended match kept
    wr(2'd0, 16'h0019);
    acc(A, 1'b1, 1'b1, 16'h1234, 1'b1, "R10");
    acc(A, 1'b1, 1'b1, 16'h12FF, 1'b0, "R10");
    // R1: reset mid-run clears hit and registers
    bus_valid = 1'b1; bus_addr = A; bus_byte = 1'b1; bus_data = 16'h1234;
    rst = 1'b1;
    cur_req = "R1";
    @(negedge clk);
    check(hit, 1'b0, "R1");
    rst = 1'b0;
    idle(1'b0, "R1");
    bus_valid = 1'b0;
    idle(1'b0, "R11");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule